// File: doc/BRIEF.md
# Debug Event Recording Controller

This block watches three kinds of debug event in a processor core: a return-from-interrupt instruction retiring, an unconditional debug request from the debug logic, and a critical interrupt being taken. Each detected event is kept in a sticky status register. Software clears the status register one bit at a time with a write-one-to-clear strobe. The block also owns the debug-interrupt enable bit. It decides whether a debug interrupt is raised at once or later, and it chooses which return address is saved for the handler.

When the enable is on, an event raises the interrupt at the edge that records it. The saved address then comes from the event itself. When the enable is off, the event is still recorded and an imprecise flag is set. The interrupt is raised later, once the enable is turned on while an event bit is still set. In that case the saved address is the one after the instruction that turned the enable on. A higher-priority-exception input holds back the interrupt while it is high.

Top module: `dbg_event_rec`

## Requirements
- R1: A return event is detected only when `ret_exec` and `ctl_ret_en` are both 1 in the same cycle. It sets status bit 0.
- R2: A critical-interrupt-taken event is detected only when `crit_take` and `ctl_crit_en` are both 1. It sets status bit 2.
- R3: `ude_req` alone is enough to detect an unconditional event. It sets status bit 1, whatever the enable bits are.
- R4: If `dbg_en` is 0 when any event is detected, status bit 3 (the imprecise flag) is also set, and no interrupt is raised at that edge.
- R5: If `dbg_en` is 1 and `hi_prio_pend` is 0 when an event is detected, `dbg_irq` goes high at the same edge that sets the status bit. `dbg_save_pc` is then `ret_pc`, `crit_pc` or `ude_pc`. When several events arrive together, return has priority over critical, and critical has priority over unconditional.
- R6: When `dbg_en` is 1 and an event status bit (0, 1 or 2) is set, with no new event in that cycle, `dbg_irq` fires one edge after `dbg_en` became 1. `dbg_save_pc` is then the `de_wr_next_pc` that came with the write that turned the enable on.
- R7: A return event with `dbg_en` at 0, written together with `de_wr`=1 and `de_wr_val`=1, records status bits 0 and 3. It then produces a delayed interrupt on the next edge, carrying `de_wr_next_pc`.
- R8: A 1 in `sts_clr` clears that status bit. Clearing every event bit before the enable is turned on cancels the delayed interrupt. An event in the same cycle as a clear of its bit leaves the bit set.
- R9: While `hi_prio_pend` is 1, `dbg_irq` stays 0. An event detected with the enable on is served once the input drops, with that event's own address.
- R10: `dbg_irq` is a one-cycle pulse. The edge that raises it forces `dbg_en` to 0, and this takes priority over an enable write in the same cycle.
- R11: After reset, `dbg_status`, `dbg_irq`, `dbg_en` and `dbg_save_pc` are all 0.
- R12: A set status bit stays set until its `sts_clr` bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ret_exec | input | 1 | A return-from-interrupt instruction executes this cycle |
| ret_pc | input | ADDR_W | Address of that return instruction |
| ude_req | input | 1 | Unconditional debug request |
| ude_pc | input | ADDR_W | Address of the instruction that would run next |
| crit_take | input | 1 | A critical interrupt is taken this cycle |
| crit_pc | input | ADDR_W | First address of the critical handler |
| ctl_ret_en | input | 1 | Control enable for return events |
| ctl_crit_en | input | 1 | Control enable for critical-taken events |
| de_wr | input | 1 | Write strobe for the debug-interrupt enable |
| de_wr_val | input | 1 | Value written to the enable |
| de_wr_next_pc | input | ADDR_W | Address after the instruction doing the write |
| hi_prio_pend | input | 1 | A higher-priority exception is pending |
| sts_clr | input | 4 | Write-one-to-clear strobe for the status bits |
| dbg_status | output | 4 | Status: bit0 return, bit1 unconditional, bit2 critical, bit3 imprecise |
| dbg_irq | output | 1 | Debug interrupt request pulse |
| dbg_save_pc | output | ADDR_W | Address saved for the debug handler |
| dbg_en | output | 1 | Current debug-interrupt enable |

## Verification
Every result is registered once after the internal reset synchroniser. Status bits, the immediate interrupt and its address appear after the edge that samples the event. A delayed interrupt appears one edge after the enable becomes visible. The bench drives inputs on the falling edge and reads outputs on the next falling edge, so every check lands exactly one edge after its stimulus. A sweep over all 64 combinations of enable, event inputs and control enables computes the expected status, interrupt, address and enable from formulas. Directed sequences then cover the hold-off, clear and simultaneous-write cases.

// File: rtl/dbg_evt_pkg.sv
package dbg_evt_pkg;
  localparam int ST_RET  = 0;
  localparam int ST_UDE  = 1;
  localparam int ST_CRIT = 2;
  localparam int ST_IMP  = 3;
  localparam int ST_W    = 4;

  typedef struct packed {
    logic crit;
    logic ude;
    logic ret;
  } evt_hits_t;
endpackage

// File: rtl/dbg_evt_detect.sv
module dbg_evt_detect
  import dbg_evt_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              ret_exec,
  input  logic              ret_en,
  input  logic [ADDR_W-1:0] ret_pc,
  input  logic              ude_req,
  input  logic [ADDR_W-1:0] ude_pc,
  input  logic              crit_take,
  input  logic              crit_en,
  input  logic [ADDR_W-1:0] crit_pc,
  output evt_hits_t         hits,
  output logic              any_hit,
  output logic [ADDR_W-1:0] hit_pc
);
  always_comb begin
    hits.ret  = ret_exec & ret_en;
    hits.crit = crit_take & crit_en;
    hits.ude  = ude_req;
    any_hit   = hits.ret | hits.crit | hits.ude;
    // fixed order: return, then critical, then unconditional
    if (hits.ret)       hit_pc = ret_pc;
    else if (hits.crit) hit_pc = crit_pc;
    else                hit_pc = ude_pc;
  end
endmodule

// File: rtl/dbg_evt_status.sv
module dbg_evt_status #(
  parameter int SW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] set_vec,
  input  logic [SW-1:0] clr_vec,
  output logic [SW-1:0] sts_q
);
  logic [SW-1:0] sts_d;

  for (genvar i = 0; i < SW; i++) begin : g_bit
    // a new event wins over a clear of the same bit
    always_comb sts_d[i] = set_vec[i] | (sts_q[i] & ~clr_vec[i]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sts_q[i] <= 1'b0;
      else        sts_q[i] <= sts_d[i];
    end
  end
endmodule

// File: rtl/dbg_evt_irq_ctl.sv
module dbg_evt_irq_ctl #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              de_wr,
  input  logic              de_wr_val,
  input  logic [ADDR_W-1:0] de_wr_next_pc,
  input  logic              hold,
  input  logic              any_hit,
  input  logic [ADDR_W-1:0] hit_pc,
  input  logic              pend_any,
  output logic              fire,
  output logic              irq_q,
  output logic [ADDR_W-1:0] save_q,
  output logic              en_q
);
  logic              en_d;
  logic [ADDR_W-1:0] resume_q, resume_d;
  logic              resume_ce;
  logic [ADDR_W-1:0] prec_q, prec_d;
  logic              prec_vld_q, prec_vld_d;
  logic              prec_ce;
  logic [ADDR_W-1:0] save_d;
  logic              save_ce;

  always_comb begin
    fire      = en_q & ~hold & (any_hit | pend_any);
    en_d      = fire ? 1'b0 : (de_wr ? de_wr_val : en_q);
    resume_ce = de_wr & de_wr_val;
    resume_d  = de_wr_next_pc;
    prec_ce   = en_q & any_hit & ~fire & ~prec_vld_q;
    prec_d    = hit_pc;
    if (fire)                  prec_vld_d = 1'b0;
    else if (de_wr & ~de_wr_val) prec_vld_d = 1'b0;
    else if (prec_ce)          prec_vld_d = 1'b1;
    else if (!pend_any)        prec_vld_d = 1'b0;
    else                       prec_vld_d = prec_vld_q;
    save_ce = fire;
    if (any_hit)         save_d = hit_pc;
    else if (prec_vld_q) save_d = prec_q;
    else                 save_d = resume_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q       <= 1'b0;
      irq_q      <= 1'b0;
      prec_vld_q <= 1'b0;
      resume_q   <= '0;
      prec_q     <= '0;
      save_q     <= '0;
    end else begin
      en_q       <= en_d;
      irq_q      <= fire;
      prec_vld_q <= prec_vld_d;
      if (resume_ce) resume_q <= resume_d;
      if (prec_ce)   prec_q   <= prec_d;
      if (save_ce)   save_q   <= save_d;
    end
  end
endmodule

// File: rtl/dbg_event_rec.sv
module dbg_event_rec
  import dbg_evt_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ret_exec,
  input  logic [ADDR_W-1:0] ret_pc,
  input  logic              ude_req,
  input  logic [ADDR_W-1:0] ude_pc,
  input  logic              crit_take,
  input  logic [ADDR_W-1:0] crit_pc,
  input  logic              ctl_ret_en,
  input  logic              ctl_crit_en,
  input  logic              de_wr,
  input  logic              de_wr_val,
  input  logic [ADDR_W-1:0] de_wr_next_pc,
  input  logic              hi_prio_pend,
  input  logic [ST_W-1:0]   sts_clr,
  output logic [ST_W-1:0]   dbg_status,
  output logic              dbg_irq,
  output logic [ADDR_W-1:0] dbg_save_pc,
  output logic              dbg_en
);
  logic              rst_meta_n, rst_sync_n;
  evt_hits_t         hits;
  logic              any_hit;
  logic [ADDR_W-1:0] hit_pc;
  logic [ST_W-1:0]   set_vec;
  logic              pend_any;
  logic              fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  dbg_evt_detect #(.ADDR_W(ADDR_W)) u_detect (
    .ret_exec  (ret_exec),
    .ret_en    (ctl_ret_en),
    .ret_pc    (ret_pc),
    .ude_req   (ude_req),
    .ude_pc    (ude_pc),
    .crit_take (crit_take),
    .crit_en   (ctl_crit_en),
    .crit_pc   (crit_pc),
    .hits      (hits),
    .any_hit   (any_hit),
    .hit_pc    (hit_pc)
  );

  always_comb begin
    set_vec          = '0;
    set_vec[ST_RET]  = hits.ret;
    set_vec[ST_UDE]  = hits.ude;
    set_vec[ST_CRIT] = hits.crit;
    set_vec[ST_IMP]  = any_hit & ~dbg_en;
    pend_any = dbg_status[ST_RET] | dbg_status[ST_UDE] | dbg_status[ST_CRIT];
  end

  dbg_evt_status #(.SW(ST_W)) u_status (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .set_vec (set_vec),
    .clr_vec (sts_clr),
    .sts_q   (dbg_status)
  );

  dbg_evt_irq_ctl #(.ADDR_W(ADDR_W)) u_irq (
    .clk           (clk),
    .rst_n         (rst_sync_n),
    .de_wr         (de_wr),
    .de_wr_val     (de_wr_val),
    .de_wr_next_pc (de_wr_next_pc),
    .hold          (hi_prio_pend),
    .any_hit       (any_hit),
    .hit_pc        (hit_pc),
    .pend_any      (pend_any),
    .fire          (fire),
    .irq_q         (dbg_irq),
    .save_q        (dbg_save_pc),
    .en_q          (dbg_en)
  );
endmodule

// File: rtl/dbg_event_rec_chk.sv
module dbg_event_rec_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ude_req,
  input logic       hi_prio_pend,
  input logic [3:0] sts_clr,
  input logic [3:0] dbg_status,
  input logic       dbg_irq,
  input logic       dbg_en
);
  for (genvar i = 0; i < 4; i++) begin : g_sticky
    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (dbg_status[i] && !sts_clr[i]) |=> dbg_status[i]); // R12
  end

  AST_UDE_RECORDED: assert property (@(posedge clk) disable iff (!rst_n)
    ude_req |=> dbg_status[1]); // R3

  AST_IMPRECISE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (ude_req && !dbg_en) |=> dbg_status[3]); // R4

  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_irq |-> $past(dbg_en)); // R4

  AST_IRQ_HELD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_irq |-> !$past(hi_prio_pend)); // R9

  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_irq |=> !dbg_irq); // R10

  AST_IRQ_DROPS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_irq |-> !dbg_en); // R10
endmodule

bind dbg_event_rec dbg_event_rec_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .ude_req      (ude_req),
  .hi_prio_pend (hi_prio_pend),
  .sts_clr      (sts_clr),
  .dbg_status   (dbg_status),
  .dbg_irq      (dbg_irq),
  .dbg_en       (dbg_en)
);

// File: tb/dbg_event_rec_bench.sv
module dbg_event_rec_bench;
  localparam int AW = 32;
  localparam logic [AW-1:0] RA = 32'h1000_0100;
  localparam logic [AW-1:0] CA = 32'h0000_0500;
  localparam logic [AW-1:0] UA = 32'h2000_0008;
  localparam logic [AW-1:0] NA = 32'h3000_0004;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          ret_exec, ude_req, crit_take, ctl_ret_en, ctl_crit_en;
  logic          de_wr, de_wr_val, hi_prio_pend;
  logic [AW-1:0] ret_pc, ude_pc, crit_pc, de_wr_next_pc;
  logic [3:0]    sts_clr;
  logic [3:0]    dbg_status;
  logic          dbg_irq, dbg_en;
  logic [AW-1:0] dbg_save_pc;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  dbg_event_rec #(.ADDR_W(AW)) u_dbg_event_rec (
    .clk(clk), .rst_n(rst_n), .ret_exec(ret_exec), .ret_pc(ret_pc),
    .ude_req(ude_req), .ude_pc(ude_pc), .crit_take(crit_take), .crit_pc(crit_pc),
    .ctl_ret_en(ctl_ret_en), .ctl_crit_en(ctl_crit_en), .de_wr(de_wr),
    .de_wr_val(de_wr_val), .de_wr_next_pc(de_wr_next_pc),
    .hi_prio_pend(hi_prio_pend), .sts_clr(sts_clr), .dbg_status(dbg_status),
    .dbg_irq(dbg_irq), .dbg_save_pc(dbg_save_pc), .dbg_en(dbg_en)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle_in();
    ret_exec = 0; ude_req = 0; crit_take = 0; ctl_ret_en = 0; ctl_crit_en = 0;
    de_wr = 0; de_wr_val = 0; hi_prio_pend = 0; sts_clr = '0;
    ret_pc = RA; ude_pc = UA; crit_pc = CA; de_wr_next_pc = NA;
  endtask

  // inputs are set at a falling edge; one rising edge; back at the falling edge
  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    idle_in();
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
  endtask

  task automatic enable_de();
    de_wr = 1; de_wr_val = 1; de_wr_next_pc = NA;
    step();
    idle_in();
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0;
    idle_in();
    @(negedge clk);
    do_reset();
    chk("R11 status", dbg_status, 4'b0000);
    chk("R11 irq", dbg_irq, 0);
    chk("R11 en", dbg_en, 0);
    chk("R11 save", dbg_save_pc, 0);

    // sweep R1 R2 R3 R4 R5 R6
    for (int k = 0; k < 64; k++) begin
      logic de, r, u, c, any;
      logic [AW-1:0] ea;
      de = k[0];
      r  = k[1] & k[4];
      u  = k[2];
      c  = k[3] & k[5];
      any = r | u | c;
      ea = r ? RA : (c ? CA : UA);
      do_reset();
      if (de) enable_de();
      ret_exec = k[1]; ude_req = k[2]; crit_take = k[3];
      ctl_ret_en = k[4]; ctl_crit_en = k[5];
      step();
      idle_in();
      chk("R1 R2 R3 R4 status", dbg_status, {~de & any, c, u, r});
      chk("R5 R4 irq", dbg_irq, de & any);
      chk("R10 en after event", dbg_en, de & ~any);
      if (de & any) chk("R5 address", dbg_save_pc, ea);
      step();
      chk("R10 single pulse", dbg_irq, 0);
      if (!de && any) begin
        enable_de();
        chk("R6 en visible", dbg_en, 1);
        chk("R6 no irq yet", dbg_irq, 0);
        step();
        chk("R6 delayed irq", dbg_irq, 1);
        chk("R6 delayed address", dbg_save_pc, NA);
        chk("R10 en dropped", dbg_en, 0);
      end
    end

    // R7 return that itself turns the enable on
    do_reset();
    ret_exec = 1; ctl_ret_en = 1; de_wr = 1; de_wr_val = 1; de_wr_next_pc = NA;
    step();
    idle_in();
    chk("R7 status", dbg_status, 4'b1001);
    chk("R7 no immediate irq", dbg_irq, 0);
    chk("R7 en", dbg_en, 1);
    step();
    chk("R7 delayed irq", dbg_irq, 1);
    chk("R7 address", dbg_save_pc, NA);
    step();
    chk("R10 pulse ends", dbg_irq, 0);

    // R8 clearing cancels the delayed interrupt
    do_reset();
    ude_req = 1;
    step();
    idle_in();
    chk("R8 recorded", dbg_status, 4'b1010);
    sts_clr = 4'b1111;
    step();
    idle_in();
    chk("R8 cleared", dbg_status, 4'b0000);
    enable_de();
    step();
    chk("R8 no irq after clear", dbg_irq, 0);
    chk("R8 en stays", dbg_en, 1);

    // R8 event beats clear, R12 sticky and per-bit clear
    do_reset();
    ude_req = 1; sts_clr = 4'b1111;
    step();
    idle_in();
    chk("R8 event over clear", dbg_status, 4'b1010);
    step(); step();
    chk("R12 sticky", dbg_status, 4'b1010);
    sts_clr = 4'b0010;
    step();
    idle_in();
    chk("R12 single clear", dbg_status, 4'b1000);

    // R9 hold-off
    do_reset();
    enable_de();
    hi_prio_pend = 1; crit_take = 1; ctl_crit_en = 1;
    step();
    crit_take = 0; ctl_crit_en = 0;
    chk("R9 held irq", dbg_irq, 0);
    chk("R9 status", dbg_status, 4'b0100);
    step(); step();
    chk("R9 still held", dbg_irq, 0);
    hi_prio_pend = 0;
    step();
    chk("R9 released irq", dbg_irq, 1);
    chk("R9 event address", dbg_save_pc, CA);
    chk("R10 en after release", dbg_en, 0);

    // R10 fire beats a same-cycle enable write
    do_reset();
    enable_de();
    ude_req = 1; de_wr = 1; de_wr_val = 1;
    step();
    idle_in();
    chk("R10 irq", dbg_irq, 1);
    chk("R10 write loses", dbg_en, 0);
    chk("R5 ude address", dbg_save_pc, UA);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule